// File: doc/BRIEF.md
# Accumulator ALU with Decimal Adjust

This block is the combinational data path that an 8-bit accumulator machine uses for every single-operand and two-operand byte operation. It takes the accumulator byte, a second operand byte, the current carry, auxiliary-carry and overflow flags, and a 5-bit operation code. In the same cycle it returns the new accumulator byte, the new second-operand byte and the three updated flags. The surrounding core fetches operands, writes results back and holds the flag register. Every operation that does not own a flag hands that flag's input value straight back out. The core can therefore write all outputs back on every operation without decoding them again.

The operations are: binary add with and without carry-in, subtract with borrow, increment and decrement, the three bitwise operations, clear, complement, four rotates, nibble swap, low-nibble exchange with the second operand, and the correction that turns a binary sum of two packed-BCD bytes into a valid BCD result.

Top module: `acc_alu`

## Requirements
- R1: Code 0 (add) returns (A + B) mod 256. Carry out is the carry from bit 7. The incoming carry has no effect.
- R2: Code 1 (add with carry) returns (A + B + C) mod 256. Carry out is the carry from bit 7.
- R3: Code 2 (subtract with borrow) returns (A − B − C) mod 256. Carry out is set exactly when A < B + C.
- R4: For codes 0, 1 and 2, auxiliary carry is the carry (for code 2, the borrow) between bit 3 and bit 4. Overflow is set exactly when the true signed result lies outside −128..127.
- R5: Code 3 (increment) and code 4 (decrement) wrap modulo 256, so FFh+1=00h and 00h−1=FFh. All three flags pass through unchanged.
- R6: Codes 5, 6 and 7 return A AND B, A OR B and A XOR B. All three flags pass through unchanged.
- R7: Code 8 returns 00h and code 9 returns the bitwise inverse of A. All three flags pass through unchanged.
- R8: Code 10 rotates A left by one bit and code 11 rotates it right by one bit, circulating only the 8 bits. Carry is unchanged.
- R9: Code 12 rotates the 9-bit value {C, A} left and code 13 rotates it right. Carry out is the bit shifted out of A: bit 7 for code 12, bit 0 for code 13. Carry in enters at the opposite end.
- R10: Code 14 returns {A[3:0], A[7:4]}. Flags are unchanged.
- R11: Code 15 returns {A[7:4], B[3:0]} as the result and {B[7:4], A[3:0]} as the second-operand output. For every other code, the second-operand output equals B.
- R12: Code 16 (decimal adjust) first adds 06h when A[3:0] > 9 or the auxiliary carry is set. It then adds 60h when the upper nibble of that sum is > 9, the carry is set, or the first step carried out. Carry out is set if carry in was set or either step carried out. This code never clears carry.
- R13: Only codes 0, 1 and 2 change the auxiliary-carry and overflow flags. All other codes, including rotates and decimal adjust, return them unchanged.
- R14: Codes 17 to 31 return A, B and all three flags unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| acc_i | input | 8 | Accumulator operand |
| opnd_i | input | 8 | Second operand byte |
| cy_i | input | 1 | Carry / borrow flag in |
| ac_i | input | 1 | Auxiliary-carry flag in |
| ov_i | input | 1 | Overflow flag in |
| op_i | input | 5 | Operation code |
| res_o | output | 8 | New accumulator value |
| opnd_o | output | 8 | New second-operand value (exchange result) |
| cy_o | output | 1 | Carry / borrow flag out |
| ac_o | output | 1 | Auxiliary-carry flag out |
| ov_o | output | 1 | Overflow flag out |

## Verification
The bound checker evaluates on every input change. It checks the properties that hold for any operand values: flags pass through for the operations that do not own them, the second operand is untouched outside the exchange, the high nibbles are preserved by the exchange, clear gives zero, the through-carry rotates take bit 7 or bit 0 into the carry, and decimal adjust never drops a carry that was set. The exact arithmetic values can only be shown by the bench scenarios, each compared with an integer reference model. These values are sums, borrows, the bit-3 carry, signed overflow and the two-step BCD correction, including the wrap and nibble-boundary cases.

// File: rtl/acc_alu_pkg.sv
`timescale 1ns/1ps
package acc_alu_pkg;
  localparam int OPW = 5;

  typedef enum logic [OPW-1:0] {
    OP_ADD  = 5'd0,
    OP_ADDC = 5'd1,
    OP_SUBB = 5'd2,
    OP_INC  = 5'd3,
    OP_DEC  = 5'd4,
    OP_AND  = 5'd5,
    OP_OR   = 5'd6,
    OP_XOR  = 5'd7,
    OP_CLR  = 5'd8,
    OP_CPL  = 5'd9,
    OP_RL   = 5'd10,
    OP_RR   = 5'd11,
    OP_RLC  = 5'd12,
    OP_RRC  = 5'd13,
    OP_SWAP = 5'd14,
    OP_XCHD = 5'd15,
    OP_DA   = 5'd16
  } alu_op_e;
endpackage

// File: rtl/acc_addsub.sv
`timescale 1ns/1ps
// Split adder: low nibble, middle bits, top bit, so that the carries
// out of bit NIB-1, bit W-2 and bit W-1 are all visible.
module acc_addsub #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  input  logic         sub,
  output logic [W-1:0] sum,
  output logic         cy,
  output logic         ac,
  output logic         ov
);
  localparam int NIB = W / 2;
  localparam int MW  = W - 1 - NIB;   // width of middle field

  logic [W-1:0] bx;
  logic         cx;
  logic [NIB:0] lo;
  logic [MW:0]  mid;
  logic [1:0]   top;

  always_comb begin
    bx  = sub ? ~b : b;
    cx  = sub ? ~cin : cin;
    lo  = {1'b0, a[NIB-1:0]} + {1'b0, bx[NIB-1:0]} + {{NIB{1'b0}}, cx};
    mid = {1'b0, a[W-2:NIB]} + {1'b0, bx[W-2:NIB]} + {{MW{1'b0}}, lo[NIB]};
    top = {1'b0, a[W-1]} + {1'b0, bx[W-1]} + {1'b0, mid[MW]};
    sum = {top[0], mid[MW-1:0], lo[NIB-1:0]};
    cy  = sub ? ~top[1] : top[1];
    ac  = sub ? ~lo[NIB] : lo[NIB];
    ov  = mid[MW] ^ top[1];
  end
endmodule

// File: rtl/acc_bitops.sv
`timescale 1ns/1ps
module acc_bitops
  import acc_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] res,
  output logic [W-1:0] b_out,
  output logic         cy
);
  localparam int NIB = W / 2;

  always_comb begin
    res   = a;
    b_out = b;
    cy    = cin;
    unique case (op)
      OP_AND:  res = a & b;
      OP_OR:   res = a | b;
      OP_XOR:  res = a ^ b;
      OP_CLR:  res = '0;
      OP_CPL:  res = ~a;
      OP_RL:   res = {a[W-2:0], a[W-1]};
      OP_RR:   res = {a[0], a[W-1:1]};
      OP_RLC: begin
        res = {a[W-2:0], cin};
        cy  = a[W-1];
      end
      OP_RRC: begin
        res = {cin, a[W-1:1]};
        cy  = a[0];
      end
      OP_SWAP: res = {a[NIB-1:0], a[W-1:NIB]};
      OP_XCHD: begin
        res   = {a[W-1:NIB], b[NIB-1:0]};
        b_out = {b[W-1:NIB], a[NIB-1:0]};
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/acc_decadj.sv
`timescale 1ns/1ps
// Two cascaded correction steps on the binary sum of two BCD bytes.
module acc_decadj #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic         cin,
  input  logic         acin,
  output logic [W-1:0] res,
  output logic         cy
);
  localparam int NIB = W / 2;
  localparam logic [NIB-1:0] DMAX  = NIB'(9);
  localparam logic [W:0]     LOFIX = (W+1)'(6);
  localparam logic [W:0]     HIFIX = LOFIX << NIB;

  logic         lo_need, hi_need;
  logic [W:0]   s1, s2;

  always_comb begin
    lo_need = (a[NIB-1:0] > DMAX) | acin;
    s1      = {1'b0, a} + (lo_need ? LOFIX : '0);
    hi_need = (s1[W-1:NIB] > DMAX) | cin | s1[W];
    s2      = {1'b0, s1[W-1:0]} + (hi_need ? HIFIX : '0);
    res     = s2[W-1:0];
    cy      = cin | s1[W] | s2[W];
  end
endmodule

// File: rtl/acc_alu.sv
`timescale 1ns/1ps
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0]   acc_i,
  input  logic [W-1:0]   opnd_i,
  input  logic           cy_i,
  input  logic           ac_i,
  input  logic           ov_i,
  input  logic [OPW-1:0] op_i,
  output logic [W-1:0]   res_o,
  output logic [W-1:0]   opnd_o,
  output logic           cy_o,
  output logic           ac_o,
  output logic           ov_o
);
  localparam logic [W-1:0] ONE = W'(1);

  alu_op_e      op;
  logic [W-1:0] add_b, add_sum, bit_res, bit_b, da_res;
  logic         add_c, add_sub, add_cy, add_ac, add_ov, bit_cy, da_cy;

  assign op = alu_op_e'(op_i);

  // Adder operand steering: increment/decrement share the adder.
  always_comb begin
    add_b   = ((op == OP_INC) || (op == OP_DEC)) ? ONE : opnd_i;
    add_c   = ((op == OP_ADDC) || (op == OP_SUBB)) ? cy_i : 1'b0;
    add_sub = (op == OP_SUBB) || (op == OP_DEC);
  end

  acc_addsub #(.W(W)) u_add (
    .a(acc_i), .b(add_b), .cin(add_c), .sub(add_sub),
    .sum(add_sum), .cy(add_cy), .ac(add_ac), .ov(add_ov)
  );

  acc_bitops #(.W(W)) u_bit (
    .op(op), .a(acc_i), .b(opnd_i), .cin(cy_i),
    .res(bit_res), .b_out(bit_b), .cy(bit_cy)
  );

  acc_decadj #(.W(W)) u_da (
    .a(acc_i), .cin(cy_i), .acin(ac_i),
    .res(da_res), .cy(da_cy)
  );

  always_comb begin
    res_o  = acc_i;
    opnd_o = opnd_i;
    cy_o   = cy_i;
    ac_o   = ac_i;
    ov_o   = ov_i;
    case (op)
      OP_ADD, OP_ADDC, OP_SUBB: begin
        res_o = add_sum;
        cy_o  = add_cy;
        ac_o  = add_ac;
        ov_o  = add_ov;
      end
      OP_INC, OP_DEC: res_o = add_sum;
      OP_AND, OP_OR, OP_XOR, OP_CLR, OP_CPL, OP_RL, OP_RR,
      OP_RLC, OP_RRC, OP_SWAP, OP_XCHD: begin
        res_o  = bit_res;
        opnd_o = bit_b;
        cy_o   = bit_cy;
      end
      OP_DA: begin
        res_o = da_res;
        cy_o  = da_cy;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/acc_alu_chk.sv
`timescale 1ns/1ps
module acc_alu_chk
  import acc_alu_pkg::*;
#(
  parameter int W = 8
) (
  input logic [W-1:0]   acc_i,
  input logic [W-1:0]   opnd_i,
  input logic           cy_i,
  input logic           ac_i,
  input logic           ov_i,
  input logic [OPW-1:0] op_i,
  input logic [W-1:0]   res_o,
  input logic [W-1:0]   opnd_o,
  input logic           cy_o,
  input logic           ac_o,
  input logic           ov_o
);
  localparam int NIB = W / 2;

  logic known, arith;

  always_comb begin
    known = !$isunknown({acc_i, opnd_i, cy_i, ac_i, ov_i, op_i});
    arith = (op_i == OP_ADD) || (op_i == OP_ADDC) || (op_i == OP_SUBB);
    if (known) begin
      a_r5_incdec_flags: assert (!((op_i == OP_INC) || (op_i == OP_DEC)) ||
                                 (cy_o == cy_i && ac_o == ac_i && ov_o == ov_i))
        else $error("incdec touched a flag");
      a_r7_clr_zero: assert (op_i != OP_CLR || res_o == '0)
        else $error("clear not zero");
      a_r9_rlc_carry: assert (op_i != OP_RLC || (cy_o == acc_i[W-1] && res_o[0] == cy_i))
        else $error("rlc carry path");
      a_r9_rrc_carry: assert (op_i != OP_RRC || (cy_o == acc_i[0] && res_o[W-1] == cy_i))
        else $error("rrc carry path");
      a_r11_opnd_pass: assert (op_i == OP_XCHD || opnd_o == opnd_i)
        else $error("second operand altered");
      a_r11_xchd_high: assert (op_i != OP_XCHD ||
                               (res_o[W-1:NIB] == acc_i[W-1:NIB] &&
                                opnd_o[W-1:NIB] == opnd_i[W-1:NIB]))
        else $error("exchange altered a high nibble");
      a_r12_da_sticky: assert (!(op_i == OP_DA && cy_i) || cy_o)
        else $error("decimal adjust cleared carry");
      a_r13_flags_hold: assert (arith || (ac_o == ac_i && ov_o == ov_i))
        else $error("aux or overflow changed");
    end
  end
endmodule

bind acc_alu acc_alu_chk #(.W(W)) u_chk (.*);

// File: tb/acc_alu_tb.sv
`timescale 1ns/1ps
module acc_alu_tb;
  logic       clk = 1'b0;
  logic [7:0] acc = 8'h00, opnd = 8'h00;
  logic       cy = 1'b0, ac = 1'b0, ov = 1'b0;
  logic [4:0] op = 5'd0;
  logic [7:0] res, opnd_out;
  logic       cy_out, ac_out, ov_out;
  int checks = 0, errors = 0, cycles = 0;

  always #2.5 clk = ~clk;

  acc_alu u_dut (
    .acc_i(acc), .opnd_i(opnd), .cy_i(cy), .ac_i(ac), .ov_i(ov), .op_i(op),
    .res_o(res), .opnd_o(opnd_out), .cy_o(cy_out), .ac_o(ac_out), .ov_o(ov_out)
  );

  function automatic int sx(input int x);
    return (x > 127) ? x - 256 : x;
  endfunction

  // Integer reference model built from the requirements.
  function automatic void model(input int o, a, b, c, h, v,
                                output int r, bo, co, ho, vo);
    int s, sv, t1, t2, c1;
    r = a; bo = b; co = c; ho = h; vo = v;
    case (o)
      0, 1: begin
        s  = a + b + ((o == 1) ? c : 0);
        r  = s & 255; co = (s > 255);
        ho = (((a & 15) + (b & 15) + ((o == 1) ? c : 0)) > 15);
        sv = sx(a) + sx(b) + ((o == 1) ? c : 0);
        vo = (sv > 127 || sv < -128);
      end
      2: begin
        s  = a - b - c;
        r  = s & 255; co = (s < 0);
        ho = (((a & 15) - (b & 15) - c) < 0);
        sv = sx(a) - sx(b) - c;
        vo = (sv > 127 || sv < -128);
      end
      3: r = (a + 1) & 255;
      4: r = (a + 255) & 255;
      5: r = a & b;
      6: r = a | b;
      7: r = a ^ b;
      8: r = 0;
      9: r = a ^ 255;
      10: r = ((a << 1) | (a >> 7)) & 255;
      11: r = (a >> 1) | ((a & 1) << 7);
      12: begin r = ((a << 1) | c) & 255; co = a >> 7; end
      13: begin r = (a >> 1) | (c << 7); co = a & 1; end
      14: r = ((a & 15) << 4) | (a >> 4);
      15: begin r = (a & 240) | (b & 15); bo = (b & 240) | (a & 15); end
      16: begin
        t1 = a + ((((a & 15) > 9) || h) ? 6 : 0);
        c1 = (t1 > 255); t1 = t1 & 255;
        t2 = t1 + ((((t1 >> 4) > 9) || c || c1) ? 96 : 0);
        co = c | c1 | (t2 > 255);
        r  = t2 & 255;
      end
      default: ;
    endcase
  endfunction

  task automatic apply(input int o, a, b, c, h, v, input string tag);
    int r, bo, co, ho, vo;
    model(o, a, b, c, h, v, r, bo, co, ho, vo);
    @(negedge clk);
    op = 5'(o); acc = 8'(a); opnd = 8'(b); cy = 1'(c); ac = 1'(h); ov = 1'(v);
    #1;
    checks++;
    if (res !== 8'(r) || opnd_out !== 8'(bo) || cy_out !== 1'(co) ||
        ac_out !== 1'(ho) || ov_out !== 1'(vo)) begin
      errors++;
      $display("FAIL %s op=%0d a=%02h b=%02h c=%0d: got res=%02h b=%02h cy=%0d ac=%0d ov=%0d exp res=%02h b=%02h cy=%0d ac=%0d ov=%0d",
               tag, o, a, b, c, res, opnd_out, cy_out, ac_out, ov_out,
               r, bo, co, ho, vo);
    end
  endtask

  task automatic t_add;  // R1 R4
    apply(0, 8'h00, 8'h00, 1, 0, 0, "R1 zero, carry ignored");
    apply(0, 8'hFF, 8'h01, 0, 0, 0, "R1 wrap");
    apply(0, 8'h0F, 8'h01, 1, 0, 0, "R4 aux carry");
    apply(0, 8'h7F, 8'h01, 0, 0, 0, "R4 overflow pos");
    apply(0, 8'h80, 8'h80, 0, 0, 0, "R4 overflow neg");
    for (int i = 0; i < 256; i += 23) apply(0, i, (i * 7) & 255, i & 1, 0, 0, "R1 sweep");
  endtask

  task automatic t_addc;  // R2 R4
    apply(1, 8'hFF, 8'h00, 1, 0, 0, "R2 carry wrap");
    apply(1, 8'h0E, 8'h01, 1, 0, 0, "R4 aux from carry");
    apply(1, 8'h3F, 8'h40, 1, 0, 0, "R4 overflow via carry");
    for (int i = 0; i < 256; i += 29) apply(1, i, 255 - i, 1, 0, 0, "R2 sweep");
  endtask

  task automatic t_subb;  // R3 R4
    apply(2, 8'h00, 8'h00, 1, 0, 0, "R3 borrow only");
    apply(2, 8'h05, 8'h05, 0, 0, 0, "R3 equal");
    apply(2, 8'h10, 8'h01, 0, 0, 0, "R4 aux borrow");
    apply(2, 8'h80, 8'h01, 0, 0, 0, "R4 overflow sub");
    apply(2, 8'h7F, 8'hFF, 0, 0, 0, "R4 overflow sub neg");
    for (int i = 0; i < 256; i += 31) apply(2, i, (i * 5 + 3) & 255, i & 1, 1, 1, "R3 sweep");
  endtask

  task automatic t_incdec;  // R5
    apply(3, 8'hFF, 8'h00, 0, 1, 1, "R5 inc wrap");
    apply(3, 8'h41, 8'h00, 1, 0, 1, "R5 inc");
    apply(4, 8'h00, 8'h00, 1, 1, 0, "R5 dec wrap");
    apply(4, 8'h10, 8'h00, 0, 0, 0, "R5 dec");
  endtask

  task automatic t_logic;  // R6 R7
    apply(5, 8'hF0, 8'h3C, 1, 1, 1, "R6 and");
    apply(6, 8'hF0, 8'h0C, 0, 1, 0, "R6 or");
    apply(7, 8'hAA, 8'hFF, 1, 0, 1, "R6 xor");
    apply(8, 8'h5A, 8'h77, 1, 1, 1, "R7 clear");
    apply(9, 8'h5A, 8'h77, 0, 0, 0, "R7 complement");
  endtask

  task automatic t_rotate;  // R8 R9
    apply(10, 8'h81, 8'h00, 0, 0, 0, "R8 rl");
    apply(11, 8'h81, 8'h00, 1, 0, 0, "R8 rr");
    apply(12, 8'h80, 8'h00, 0, 1, 1, "R9 rlc out");
    apply(12, 8'h01, 8'h00, 1, 0, 0, "R9 rlc in");
    apply(13, 8'h01, 8'h00, 0, 0, 1, "R9 rrc out");
    apply(13, 8'h80, 8'h00, 1, 1, 0, "R9 rrc in");
  endtask

  task automatic t_nibbles;  // R10 R11
    apply(14, 8'h3C, 8'h11, 1, 0, 1, "R10 swap");
    apply(15, 8'h12, 8'hAB, 0, 1, 0, "R11 exchange");
    apply(15, 8'hF0, 8'h0F, 1, 0, 1, "R11 exchange edge");
  endtask

  task automatic t_decadj;  // R12 R13
    apply(16, 8'h9A, 8'h00, 0, 0, 0, "R12 both digits");
    apply(16, 8'h15, 8'h00, 0, 1, 1, "R12 aux set");
    apply(16, 8'h45, 8'h00, 1, 0, 0, "R12 carry sticky");
    apply(16, 8'h99, 8'h00, 0, 0, 0, "R12 valid bcd");
    apply(16, 8'hFA, 8'h00, 0, 0, 1, "R12 low step carry");
    apply(16, 8'h0A, 8'h00, 0, 1, 0, "R13 flags held");
  endtask

  task automatic t_unused;  // R14
    apply(17, 8'h5C, 8'hC5, 1, 0, 1, "R14 code 17");
    apply(31, 8'hA3, 8'h3A, 0, 1, 0, "R14 code 31");
  endtask

  task automatic finish_run;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    #1;
    checks++;
    if (res !== 8'h00 || cy_out !== 1'b0) begin
      errors++;
      $display("FAIL R1 initial add of zeros: res=%02h cy=%0d exp 00 0", res, cy_out);
    end
    t_add();
    t_addc();
    t_subb();
    t_incdec();
    t_logic();
    t_rotate();
    t_nibbles();
    t_decadj();
    t_unused();
    finish_run();
  end
endmodule